// File: doc/BRIEF.md
# Coincident-Select Destructive-Read Memory Sequencer

This block runs the access cycle for a two-dimensional grid of bistable storage cells whose read operation wipes the stored bit, in the manner of a magnetic-core plane. A host hands it one request at a time: a read or a write, a cell address and, for a write, a data bit. The sequencer latches the request and splits the address into a row index and a column index. It then drives exactly one row line and one column line together, each at half strength, so that only the cell at their crossing sees enough drive to change state.

Every access starts with a clear phase that pushes the selected cell toward 0. A cell that held 1 flips and produces a pulse on the single sense line that all cells share. The sequencer accepts that pulse only inside a fixed window of clear-phase cycles. After a short gap with all drives released, it enters a set phase with the polarity output raised. For a read, the set phase runs only when the sensed bit was 1, so the value the read destroyed is restored. For a write, the sensed bit is dropped and the set phase runs only when the new bit is 1. A one-cycle response pulse ends each access. The sense amplifier and the current drivers sit outside the block.

Top module: `dr_core_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `req_ready` is 1 and `rsp_valid`, `drv_set`, every row line and every column line are all 0.
- R2: The address is `{row, column}`, with the column index in the low log2(COLS) bits. Row and column lines are active together or not at all. At most one of each is active, and the active pair is the row and column of the accepted request, held steady for the whole access.
- R3: A read drives a clear phase of DRIVE_CYC cycles with `drv_set` at 0. A sense pulse captured in that phase makes `rsp_rdata` 1, and no captured pulse makes it 0.
- R4: The sense input counts only in clear-phase cycles WIN_FIRST through WIN_LAST, both ends included, where the first clear cycle is index 0. Pulses in any other clear cycle, and pulses while idle, leave the result at 0.
- R5: A read that sensed 1 is followed by a set phase of DRIVE_CYC cycles on the same cell, so the cell holds 1 again afterwards. A read that sensed 0 has no set phase.
- R6: A write clears the cell and then runs a set phase only when `req_wdata` is 1. Its sensed bit is discarded, and `rsp_rdata` keeps the value of the most recent read.
- R7: `drv_set` never changes while the drive lines stay active from one cycle to the next. At least one cycle with every line released separates the clear and set phases.
- R8: `rsp_valid` is a single-cycle pulse. Counting clock edges from the edge that accepts the request, it goes high after 2*DRIVE_CYC+1 edges when a set phase runs, and after DRIVE_CYC+1 edges otherwise.
- R9: `req_ready` is 1 only when the block is idle. It falls after the accepting edge and rises again after the response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle; a request is taken on an edge where both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | log2(ROWS)+log2(COLS) | Cell address, `{row, column}` |
| req_wdata | input | 1 | Bit to store on a write |
| rsp_valid | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 1 | Bit recovered by the latest read |
| row_drv | output | ROWS | Row half-drive enables |
| col_drv | output | COLS | Column half-drive enables |
| drv_set | output | 1 | Drive polarity: 1 pushes toward 1, 0 pushes toward 0 |
| sense_in | input | 1 | Shared sense-line pulse |

## Verification
The bench builds the block with a 4-row by 8-column grid, DRIVE_CYC of 4 and a sense window over clear cycles 1 to 2. The short phases keep each access to about ten cycles, so every one of the 32 cells can be written and read back. With a four-cycle clear phase, a stray pulse can be placed in the cycle before the window, in the last cycle of the window and in the cycle after it. The bench models the cells itself and raises a flip pulse only when the crossing cell actually changes from 1 to 0. Write-back and isolation from neighbouring cells therefore appear directly in the values read back.

// File: rtl/dr_core_pkg.sv
package dr_core_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_GAP,
    ST_SET,
    ST_DONE
  } dr_state_e;

  // True when a clear-phase cycle index falls inside the sense window.
  function automatic logic in_window(input int unsigned idx,
                                     input int unsigned first,
                                     input int unsigned last);
    return (idx >= first) && (idx <= last);
  endfunction

  // Edges from acceptance to the response pulse.
  function automatic int unsigned op_cycles(input int unsigned drive_cyc,
                                            input logic set_phase);
    return set_phase ? (2 * drive_cyc + 1) : (drive_cyc + 1);
  endfunction

endpackage

// File: rtl/dr_line_decode.sv
module dr_line_decode #(
  parameter int unsigned N  = 8,
  parameter int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  input  logic          en,
  output logic [N-1:0]  line
);

  for (genvar i = 0; i < N; i++) begin : g_line
    assign line[i] = en && (sel == SW'(i));
  end

  // R2: never more than one line of this dimension active
  p_line_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line));

  // R2: an enabled decode always reaches some line (address in range)
  p_line_reached_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (line != '0));

endmodule

// File: rtl/dr_sense_win.sv
module dr_sense_win
  import dr_core_pkg::*;
#(
  parameter int unsigned CW        = 3,
  parameter int unsigned WIN_FIRST = 2,
  parameter int unsigned WIN_LAST  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          phase_clr,
  input  logic [CW-1:0] cnt,
  input  logic          sense_in,
  output logic          win,
  output logic          sensed
);

  logic sensed_q;

  assign win    = phase_clr && in_window(32'(cnt), WIN_FIRST, WIN_LAST);
  assign sensed = sensed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sensed_q <= 1'b0;
    else if (clear)          sensed_q <= 1'b0;
    else if (win && sense_in) sensed_q <= 1'b1;
  end

  // R4: the captured bit only rises from a pulse seen inside the window
  p_capture_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sensed_q) |-> $past(win && sense_in));

  // R4: outside the clear phase the captured bit never rises
  p_no_capture_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_clr && !sensed_q) |=> !sensed_q);

endmodule

// File: rtl/dr_seq.sv
module dr_seq
  import dr_core_pkg::*;
#(
  parameter int unsigned DRIVE_CYC = 6,
  parameter int unsigned CW        = $clog2(DRIVE_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_wdata,
  input  logic          sensed,
  output logic          req_ready,
  output logic          start,
  output logic          phase_clr,
  output logic          phase_set,
  output logic [CW-1:0] cnt,
  output logic          rsp_valid,
  output logic          rsp_rdata
);

  localparam logic [CW-1:0] LAST = CW'(DRIVE_CYC - 1);
  localparam int unsigned   LW   = $clog2(2 * DRIVE_CYC + 3);

  dr_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          op_write_q, op_wdata_q, rdata_q;
  logic          wbit;

  assign req_ready = (state_q == ST_IDLE);
  assign start     = req_valid && req_ready;
  assign phase_clr = (state_q == ST_CLR);
  assign phase_set = (state_q == ST_SET);
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_rdata = rdata_q;
  assign cnt       = cnt_q;
  assign wbit      = op_write_q ? op_wdata_q : sensed;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_CLR;
      ST_CLR:  if (cnt_q == LAST) state_d = ST_GAP;
      ST_GAP:  state_d = wbit ? ST_SET : ST_DONE;
      ST_SET:  if (cnt_q == LAST) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if ((state_d == state_q) && ((state_q == ST_CLR) || (state_q == ST_SET)))
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      op_write_q <= 1'b0;
      op_wdata_q <= 1'b0;
      rdata_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (start) begin
        op_write_q <= req_write;
        op_wdata_q <= req_wdata;
      end
      if ((state_q == ST_GAP) && !op_write_q) rdata_q <= sensed;
    end
  end

  // Observation state for the latency property
  logic [LW-1:0] lat_q;
  logic          set_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q      <= '0;
      set_seen_q <= 1'b0;
    end else begin
      if (start) begin
        lat_q      <= '0;
        set_seen_q <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        lat_q <= lat_q + 1'b1;
        if (state_q == ST_SET) set_seen_q <= 1'b1;
      end
    end
  end

  // R5: a read that sensed 1 always enters the restoring set phase
  p_wb_after_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_GAP) && !op_write_q && sensed) |=> phase_set);

  // R6: a write of 0 never enters the set phase
  p_write_zero_skips_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_GAP) && op_write_q && !op_wdata_q) |=> rsp_valid);

  // R8: response lands exactly the expected number of edges after acceptance
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (32'(lat_q) == op_cycles(DRIVE_CYC, set_seen_q)));

  // R8: response is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: busy after acceptance, idle after the response
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_ready);
  p_ready_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

endmodule

// File: rtl/dr_core_ctrl.sv
module dr_core_ctrl #(
  parameter int unsigned ROWS      = 8,
  parameter int unsigned COLS      = 8,
  parameter int unsigned DRIVE_CYC = 6,
  parameter int unsigned WIN_FIRST = 2,
  parameter int unsigned WIN_LAST  = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [$clog2(ROWS)+$clog2(COLS)-1:0]  req_addr,
  input  logic                                  req_wdata,
  output logic                                  rsp_valid,
  output logic                                  rsp_rdata,
  output logic [ROWS-1:0]                       row_drv,
  output logic [COLS-1:0]                       col_drv,
  output logic                                  drv_set,
  input  logic                                  sense_in
);

  localparam int unsigned RSW = $clog2(ROWS);
  localparam int unsigned CSW = $clog2(COLS);
  localparam int unsigned AW  = RSW + CSW;
  localparam int unsigned CW  = $clog2(DRIVE_CYC + 1);

  logic           start, phase_clr, phase_set, drive_on;
  logic [CW-1:0]  cnt;
  logic           win, sensed;
  logic [RSW-1:0] row_q;
  logic [CSW-1:0] col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (start) begin
      row_q <= req_addr[AW-1:CSW];
      col_q <= req_addr[CSW-1:0];
    end
  end

  assign drive_on = phase_clr || phase_set;
  assign drv_set  = phase_set;

  dr_seq #(.DRIVE_CYC(DRIVE_CYC), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .sensed    (sensed),
    .req_ready (req_ready),
    .start     (start),
    .phase_clr (phase_clr),
    .phase_set (phase_set),
    .cnt       (cnt),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  dr_sense_win #(.CW(CW), .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .phase_clr (phase_clr),
    .cnt       (cnt),
    .sense_in  (sense_in),
    .win       (win),
    .sensed    (sensed)
  );

  dr_line_decode #(.N(ROWS), .SW(RSW)) u_row_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (row_q),
    .en    (drive_on),
    .line  (row_drv)
  );

  dr_line_decode #(.N(COLS), .SW(CSW)) u_col_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (col_q),
    .en    (drive_on),
    .line  (col_drv)
  );

  // R2: row and column half-drives appear together or not at all
  p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_drv != '0) == (col_drv != '0));

  // R2: the selected crossing does not move during an access
  p_sel_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_drv != '0) && $past(row_drv != '0)) |->
      ($stable(row_drv) && $stable(col_drv)));

  // R7: polarity holds while the lines stay driven
  p_pol_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_drv != '0) && $past(row_drv != '0)) |-> $stable(drv_set));

  // R7: the set phase starts only after a released cycle
  p_gap_before_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_set) |-> $past(row_drv == '0));

  // R3/R4: the sense window only exists in the clear phase
  p_win_in_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> ((row_drv != '0) && !drv_set));

endmodule

// File: tb/test_dr_core_ctrl.sv
module test_dr_core_ctrl;

  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int D    = 4;
  localparam int WF   = 1;
  localparam int WL   = 2;
  localparam int AW   = 5;
  localparam int NC   = ROWS * COLS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write, req_wdata;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, rsp_rdata;
  logic [ROWS-1:0] row_drv;
  logic [COLS-1:0] col_drv;
  logic          drv_set;
  logic          sense_in;

  dr_core_ctrl #(.ROWS(ROWS), .COLS(COLS), .DRIVE_CYC(D),
                 .WIN_FIRST(WF), .WIN_LAST(WL)) i_dr_core_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .row_drv(row_drv),
    .col_drv(col_drv), .drv_set(drv_set), .sense_in(sense_in)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural cell plane
  bit cells[NC];
  bit shadow[NC];
  int age = 0;
  int noise_age = 0;
  bit idle_noise = 0;
  bit drv_bad = 0, pol_bad = 0, prev_on = 0, prev_set = 0;
  int cur_row = 0, cur_col = 0;

  always @(negedge clk) begin
    bit on;
    int idx;
    on  = (row_drv != '0) || (col_drv != '0);
    idx = cur_row * COLS + cur_col;
    if (on) begin
      if ($countones(row_drv) != 1 || $countones(col_drv) != 1 ||
          !row_drv[cur_row] || !col_drv[cur_col]) drv_bad = 1;
      if (prev_on && (drv_set != prev_set)) pol_bad = 1;
    end
    prev_on  = on;
    prev_set = drv_set;
    sense_in = idle_noise;
    if (on && !drv_set) begin
      age++;
      if (noise_age != 0 && age == noise_age) sense_in = 1'b1;
      if (age == WF + 1 && cells[idx]) begin
        sense_in   = 1'b1;
        cells[idx] = 1'b0;
      end
    end else if (on && drv_set) begin
      cells[idx] = 1'b1;
      age = 0;
    end else begin
      age = 0;
    end
  end

  // Scoreboard
  typedef struct { bit exp_rd; int exp_lat; int t0; } item_t;
  item_t sbq[$];
  int n_ops = 0;
  int rsp_seen = 0;
  bit last_rd = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      item_t it;
      if (sbq.size() == 0) begin
        chk(0, "R8 unexpected response", 1, 0);
      end else begin
        it = sbq.pop_front();
        chk(rsp_rdata == it.exp_rd, "R3/R6 rdata", int'(rsp_rdata), int'(it.exp_rd));
        chk((cyc - it.t0) == it.exp_lat, "R8 latency", cyc - it.t0, it.exp_lat);
        chk(!drv_bad, "R2 drive select", int'(drv_bad), 0);
        chk(!pol_bad, "R7 polarity", int'(pol_bad), 0);
      end
      drv_bad = 0;
      pol_bad = 0;
      rsp_seen++;
    end
  end

  task automatic op(input bit wr, input int addr, input bit wd);
    item_t it;
    bit    setb;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(addr);
    req_wdata = wd;
    cur_row   = addr / COLS;
    cur_col   = addr % COLS;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    setb      = wr ? wd : shadow[addr];
    it.exp_rd = wr ? last_rd : shadow[addr];
    if (!wr) last_rd = shadow[addr];
    it.exp_lat = setb ? (2 * D + 1) : (D + 1);
    it.t0      = cyc;
    sbq.push_back(it);
    shadow[addr] = setb;
    n_ops++;
    while (rsp_seen < n_ops) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = 1'b0; sense_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while held
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk(row_drv == '0 && col_drv == '0, "R1 drives in reset", int'(row_drv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && drv_set == 1'b0, "R1 outputs after reset",
        int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // R6: writes of 1 and 0 into distinct cells
    op(1, 5, 1);
    op(1, 31, 1);
    op(1, 0, 1);
    op(1, 12, 0);
    chk(cells[5] == 1'b1, "R6 cell set by write", int'(cells[5]), 1);

    // R3: reads of a 1 and of a 0
    op(0, 5, 0);
    op(0, 12, 0);
    // R5: repeated read of the same 1 keeps it (write-back)
    op(0, 5, 0);
    chk(cells[5] == 1'b1, "R5 cell restored", int'(cells[5]), 1);
    op(0, 31, 0);
    op(0, 0, 0);

    // R4: pulses before and after the window are ignored
    noise_age = WF;
    op(0, 12, 0);
    noise_age = WL + 2;
    op(0, 12, 0);
    // R4: idle pulses are ignored
    noise_age  = 0;
    idle_noise = 1'b1;
    repeat (5) @(negedge clk);
    idle_noise = 1'b0;
    op(0, 12, 0);
    // R4: a pulse in the last window cycle counts as a stored 1
    noise_age  = WL + 1;
    shadow[12] = 1'b1;
    op(0, 12, 0);
    noise_age = 0;
    chk(cells[12] == 1'b1, "R4 window edge write-back", int'(cells[12]), 1);

    // R6: overwrite a 1 with 0, rdata keeps last read value
    op(1, 5, 0);
    op(0, 5, 0);

    // R9: busy while an access runs, idle after it
    fork
      op(0, 31, 0);
      begin
        @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 busy during access", int'(req_ready), 0);
      end
    join
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after response", int'(req_ready), 1);

    // R2: sweep every cell with a pattern, then read all back
    for (int a = 0; a < NC; a++) op(1, a, bit'(((a * 5) >> 1) & 1));
    for (int a = 0; a < NC; a++) op(0, a, 0);
    for (int a = 0; a < NC; a++) op(1, a, bit'(~(((a * 5) >> 1) & 1)));
    for (int a = 0; a < NC; a++) op(0, a, 0);

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R8 all responses seen", sbq.size(), 0);
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule